// File: doc/BRIEF.md
# Framed Register-Write Command Decoder

The block takes a byte stream, one byte per handshake cycle, and splits it into framed commands. Each command opens with the prefix byte 0xAF and an opcode byte. A register-write command loads one byte into a bank of 8-bit registers that is addressed by an 8-bit index. A fixed-length copy command is consumed whole, and its fields are reported on a side output for a copy engine that sits outside this block.

Register writes can be staged. A lock write sends later writes only to a shadow bank. The matching unlock write copies the whole shadow bank into the active bank in one cycle, so a display timing generator never sees a half-updated mode. The colour-depth selector, the two frame base pointers, the active-size and pixel-clock words and the ten timing comparator words are read from the active bank and driven on parallel outputs. Each is assembled in the byte order its register pair uses. A byte that breaks the framing, or an opcode the block does not know, sets a sticky error flag. The decoder then waits for the next prefix byte.

Top module: `pcd_cmd_decoder`

## Requirements
- R1: After reset, every register output, `locked`, `err_flag`, `commit` and `copy_valid` are 0, and `in_ready` is 1.
- R2: The sequence 0xAF, 0x20, address, data writes data to the register at that address. When the bank is unlocked, the value appears on the outputs in the cycle after the data byte is accepted. Register 0x00 drives `depth_sel`.
- R3: The pairs 0x0F/0x10 (`hpix`) and 0x17/0x18 (`vpix`) hold their high byte at the lower address. The pair 0x1B/0x1C (`pclk5k`) holds its low byte at the lower address. The base pointers 0x20..0x22 (`base16`) and 0x26..0x28 (`base8`) hold their most significant byte at the lowest address.
- R4: A write of 0x00 to address 0xFF sets `locked`. While it is set, register writes change only the shadow bank and the active outputs hold.
- R5: A write of 0xFF to address 0xFF copies the whole shadow bank to the active bank in one cycle. It clears `locked` and raises `commit` for exactly one cycle, in the cycle after the data byte.
- R6: The copy command is nine bytes: 0xAF, 0x6A, a 3-byte source address with the most significant byte first, a 1-byte pixel count, and a 3-byte destination address with the most significant byte first. `copy_valid` is high for one cycle after the last byte, with `copy_src`, `copy_len` and `copy_dst` valid.
- R7: A prefix that is followed by another prefix, or that ends the stream, is padding. It raises no error, and the next command is decoded normally.
- R8: A byte other than 0xAF where a prefix is expected sets `err_flag`, which stays set until reset. The decoder resynchronises on the next 0xAF.
- R9: After a prefix, an opcode other than 0x20, 0x6A or 0xAF sets `err_flag` and drops the command. The bytes that follow are not taken as its payload.
- R10: A write to address 0xFF with a data value other than 0x00 or 0xFF changes neither `locked` nor the active bank, and raises no `commit`.
- R11: `timing_bus` word i (bits 16i+15..16i) holds a register pair with its high byte at the lower address. The pairs start at 0x01, 0x03, 0x05, 0x07, 0x09, 0x0B and 0x0D for i = 0..6, and at 0x11, 0x13 and 0x15 for i = 7..9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | 8 | Input stream byte |
| in_ready | output | 1 | Byte accepted (always 1) |
| err_flag | output | 1 | Sticky framing or opcode error |
| locked | output | 1 | Writes are being staged in the shadow bank |
| commit | output | 1 | One-cycle pulse when the shadow bank is committed |
| copy_valid | output | 1 | One-cycle pulse: copy command decoded |
| copy_src | output | 24 | Copy source address |
| copy_len | output | 8 | Copy pixel count |
| copy_dst | output | 24 | Copy destination address |
| depth_sel | output | 8 | Colour depth selector (0 = 16bpp) |
| base16 | output | 24 | 16bpp frame base pointer |
| base8 | output | 24 | 8bpp frame base pointer |
| hpix | output | 16 | Active pixels per line |
| vpix | output | 16 | Active lines |
| pclk5k | output | 16 | Pixel clock in 5 kHz units |
| timing_bus | output | 160 | Ten timing comparator words |
| active_regs | output | 8*NREG (512) | Whole active bank, register k at bits 8k+7..8k |

## Verification
Every result is registered once after the clock edge that accepts the last byte of a command. A register write, a commit or a copy therefore shows at the ports one cycle after that byte. The bench drives bytes at the falling edge and reads every output at the following falling edge. That is the first sample point after the accepting rising edge, and it is also the only sample point that sees a one-cycle pulse. Expected commit and copy events are queued by the driver and popped by a monitor that runs at the same falling edge. A pulse with nothing queued, or a queue left with entries at the end, counts as a failure.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    localparam logic [7:0] PFX_BYTE   = 8'hAF;
    localparam logic [7:0] OPC_WRITE  = 8'h20;
    localparam logic [7:0] OPC_COPY   = 8'h6A;
    localparam logic [7:0] CTRL_ADDR  = 8'hFF;
    localparam logic [7:0] CTRL_LOCK  = 8'h00;
    localparam logic [7:0] CTRL_UNLK  = 8'hFF;

    // Register indices with fixed meaning
    localparam int REG_DEPTH  = 8'h00;
    localparam int REG_HPIX   = 8'h0F;
    localparam int REG_VPIX   = 8'h17;
    localparam int REG_PCLK   = 8'h1B;
    localparam int REG_BASE16 = 8'h20;
    localparam int REG_BASE8  = 8'h26;
    localparam int TIMING_WORDS = 10;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPC,
        S_ADDR,
        S_DATA,
        S_COPY
    } fr_state_e;

endpackage

// File: rtl/pcd_framer.sv
module pcd_framer
    import pcd_pkg::*;
#(
    parameter int ADDR_BYTES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    byte_v,
    input  logic [7:0]              byte_d,
    output logic                    wr_v,
    output logic [7:0]              wr_addr,
    output logic [7:0]              wr_data,
    output logic                    cpy_v,
    output logic [8*ADDR_BYTES-1:0] cpy_src,
    output logic [7:0]              cpy_len,
    output logic [8*ADDR_BYTES-1:0] cpy_dst,
    output logic                    err
);

    localparam int PAY_BYTES = 2 * ADDR_BYTES + 1;
    localparam int FW        = 8 * PAY_BYTES;
    localparam int SHW       = FW - 8;
    localparam int CW        = $clog2(PAY_BYTES);
    localparam int AW        = 8 * ADDR_BYTES;

    typedef struct packed {
        fr_state_e       st;
        logic [CW-1:0]   cnt;
        logic [7:0]      addr;
        logic [SHW-1:0]  sh;
        logic            cv;
        logic [FW-1:0]   cf;
        logic            err;
    } fr_t;

    fr_t q, d;

    always_comb begin
        d    = q;
        d.cv = 1'b0;
        if (byte_v) begin
            case (q.st)
                S_IDLE: begin
                    if (byte_d == PFX_BYTE) d.st = S_OPC;
                    else                    d.err = 1'b1;
                end
                S_OPC: begin
                    if (byte_d == OPC_WRITE) begin
                        d.st = S_ADDR;
                    end else if (byte_d == OPC_COPY) begin
                        d.st  = S_COPY;
                        d.cnt = '0;
                    end else if (byte_d == PFX_BYTE) begin
                        d.st = S_OPC;   // previous prefix was padding
                    end else begin
                        d.err = 1'b1;
                        d.st  = S_IDLE;
                    end
                end
                S_ADDR: begin
                    d.addr = byte_d;
                    d.st   = S_DATA;
                end
                S_DATA: begin
                    d.st = S_IDLE;
                end
                S_COPY: begin
                    d.sh = {q.sh[SHW-9:0], byte_d};
                    if (q.cnt == CW'(PAY_BYTES - 1)) begin
                        d.cv = 1'b1;
                        d.cf = {q.sh, byte_d};
                        d.st = S_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wr_v    = byte_v && (q.st == S_DATA);
    assign wr_addr = q.addr;
    assign wr_data = byte_d;
    assign cpy_v   = q.cv;
    assign cpy_src = q.cf[FW-1 -: AW];
    assign cpy_len = q.cf[AW +: 8];
    assign cpy_dst = q.cf[AW-1:0];
    assign err     = q.err;

endmodule

// File: rtl/pcd_regbank.sv
module pcd_regbank
    import pcd_pkg::*;
#(
    parameter int NREG = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_v,
    input  logic [7:0]           wr_addr,
    input  logic [7:0]           wr_data,
    output logic [NREG-1:0][7:0] act,
    output logic                 locked,
    output logic                 commit
);

    localparam int         IW    = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [8:0] LIMIT = 9'(NREG);

    typedef struct packed {
        logic [NREG-1:0][7:0] sh;
        logic [NREG-1:0][7:0] act;
        logic                 lk;
        logic                 cm;
    } rb_t;

    rb_t q, d;

    always_comb begin
        d    = q;
        d.cm = 1'b0;
        if (wr_v) begin
            if (wr_addr == CTRL_ADDR) begin
                if (wr_data == CTRL_LOCK) begin
                    d.lk = 1'b1;
                end else if (wr_data == CTRL_UNLK) begin
                    d.act = q.sh;
                    d.lk  = 1'b0;
                    d.cm  = 1'b1;
                end
            end else if ({1'b0, wr_addr} < LIMIT) begin
                d.sh[wr_addr[IW-1:0]] = wr_data;
                if (!q.lk) d.act[wr_addr[IW-1:0]] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign act    = q.act;
    assign locked = q.lk;
    assign commit = q.cm;

endmodule

// File: rtl/pcd_fieldmap.sv
module pcd_fieldmap
    import pcd_pkg::*;
#(
    parameter int NREG = 64
) (
    input  logic [NREG-1:0][7:0]       act,
    output logic [7:0]                 depth_sel,
    output logic [23:0]                base16,
    output logic [23:0]                base8,
    output logic [15:0]                hpix,
    output logic [15:0]                vpix,
    output logic [15:0]                pclk5k,
    output logic [16*TIMING_WORDS-1:0] timing_bus,
    output logic [8*NREG-1:0]          bank_flat
);

    assign depth_sel = act[REG_DEPTH];
    assign hpix      = {act[REG_HPIX], act[REG_HPIX+1]};
    assign vpix      = {act[REG_VPIX], act[REG_VPIX+1]};
    assign pclk5k    = {act[REG_PCLK+1], act[REG_PCLK]};
    assign base16    = {act[REG_BASE16], act[REG_BASE16+1], act[REG_BASE16+2]};
    assign base8     = {act[REG_BASE8], act[REG_BASE8+1], act[REG_BASE8+2]};
    assign bank_flat = act;

    for (genvar gi = 0; gi < TIMING_WORDS; gi++) begin : g_tw
        localparam int A = (gi < 7) ? (1 + 2 * gi) : (8'h11 + 2 * (gi - 7));
        assign timing_bus[16*gi +: 16] = {act[A], act[A+1]};
    end

endmodule

// File: rtl/pcd_cmd_decoder.sv
module pcd_cmd_decoder
    import pcd_pkg::*;
#(
    parameter int NREG       = 64,
    parameter int ADDR_BYTES = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [7:0]                 in_data,
    output logic                       in_ready,
    output logic                       err_flag,
    output logic                       locked,
    output logic                       commit,
    output logic                       copy_valid,
    output logic [8*ADDR_BYTES-1:0]    copy_src,
    output logic [7:0]                 copy_len,
    output logic [8*ADDR_BYTES-1:0]    copy_dst,
    output logic [7:0]                 depth_sel,
    output logic [23:0]                base16,
    output logic [23:0]                base8,
    output logic [15:0]                hpix,
    output logic [15:0]                vpix,
    output logic [15:0]                pclk5k,
    output logic [16*TIMING_WORDS-1:0] timing_bus,
    output logic [8*NREG-1:0]          active_regs
);

    logic                 wr_v;
    logic [7:0]           wr_addr;
    logic [7:0]           wr_data;
    logic [NREG-1:0][7:0] act;

    assign in_ready = 1'b1;

    pcd_framer #(.ADDR_BYTES(ADDR_BYTES)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_v  (in_valid && in_ready),
        .byte_d  (in_data),
        .wr_v    (wr_v),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cpy_v   (copy_valid),
        .cpy_src (copy_src),
        .cpy_len (copy_len),
        .cpy_dst (copy_dst),
        .err     (err_flag)
    );

    pcd_regbank #(.NREG(NREG)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_v    (wr_v),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .act     (act),
        .locked  (locked),
        .commit  (commit)
    );

    pcd_fieldmap #(.NREG(NREG)) u_map (
        .act        (act),
        .depth_sel  (depth_sel),
        .base16     (base16),
        .base8      (base8),
        .hpix       (hpix),
        .vpix       (vpix),
        .pclk5k     (pclk5k),
        .timing_bus (timing_bus),
        .bank_flat  (active_regs)
    );

endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
    parameter int NREG = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             err_flag,
    input logic             locked,
    input logic             commit,
    input logic             copy_valid,
    input logic [8*NREG-1:0] active_regs
);

    // R4: active bank frozen across a cycle in which the lock held
    p_locked_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(locked) && locked) |-> $stable(active_regs));

    // R5: a commit always leaves the bank unlocked
    p_commit_unlocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !locked);

    // R5: commit strobe lasts one cycle
    p_commit_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R6: copy report lasts one cycle
    p_copy_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        copy_valid |=> !copy_valid);

    // R8: error flag is sticky
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

endmodule

bind pcd_cmd_decoder pcd_checker #(.NREG(NREG)) u_pcd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_flag    (err_flag),
    .locked      (locked),
    .commit      (commit),
    .copy_valid  (copy_valid),
    .active_regs (active_regs)
);

// File: tb/tb_pcd_cmd_decoder.sv
`timescale 1ns/1ps
module tb_pcd_cmd_decoder;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [7:0]   in_data = 8'h00;
    logic         in_ready, err_flag, locked, commit, copy_valid;
    logic [23:0]  copy_src, copy_dst, base16, base8;
    logic [7:0]   copy_len, depth_sel;
    logic [15:0]  hpix, vpix, pclk5k;
    logic [159:0] timing_bus;
    logic [511:0] active_regs;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit          is_copy;
        logic [23:0] src;
        logic [7:0]  len;
        logic [23:0] dst;
        logic [15:0] hp;
        logic [23:0] b8;
    } exp_t;
    exp_t expq[$];

    always #2 clk = ~clk;

    pcd_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .err_flag(err_flag), .locked(locked), .commit(commit),
        .copy_valid(copy_valid), .copy_src(copy_src), .copy_len(copy_len),
        .copy_dst(copy_dst), .depth_sel(depth_sel), .base16(base16), .base8(base8),
        .hpix(hpix), .vpix(vpix), .pclk5k(pclk5k), .timing_bus(timing_bus),
        .active_regs(active_regs)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        send(8'hAF); send(8'h20); send(a); send(v); idle();
    endtask

    // Monitor: pops expected events at the sample point after each pulse
    always @(negedge clk) begin
        if (rst_n && (commit || copy_valid)) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R5/R6: unexpected event commit=%b copy=%b expected none", commit, copy_valid);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (e.is_copy) begin
                    if (!copy_valid || commit || copy_src !== e.src || copy_len !== e.len || copy_dst !== e.dst) begin
                        errors++;
                        $display("FAIL R6: copy actual %h/%h/%h expected %h/%h/%h",
                                 copy_src, copy_len, copy_dst, e.src, e.len, e.dst);
                    end
                end else begin
                    if (!commit || copy_valid || hpix !== e.hp || base8 !== e.b8) begin
                        errors++;
                        $display("FAIL R5: commit hpix %h base8 %h expected %h %h",
                                 hpix, base8, e.hp, e.b8);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 regs", {8'h0, base16}, 32'h0);
        chk("R1 hpix", {16'h0, hpix}, 32'h0);
        chk("R1 flags", {27'h0, in_ready, err_flag, locked, commit, copy_valid}, 32'h10);

        // R2
        wr(8'h00, 8'h01);
        chk("R2 depth", {24'h0, depth_sel}, 32'h01);

        // R3
        wr(8'h0F, 8'h05); wr(8'h10, 8'h00);
        chk("R3 hpix", {16'h0, hpix}, 32'h0500);
        wr(8'h17, 8'h03); wr(8'h18, 8'h20);
        chk("R3 vpix", {16'h0, vpix}, 32'h0320);
        wr(8'h1B, 8'h34); wr(8'h1C, 8'h12);
        chk("R3 pclk", {16'h0, pclk5k}, 32'h1234);
        wr(8'h20, 8'h01); wr(8'h21, 8'h02); wr(8'h22, 8'h03);
        chk("R3 base16", {8'h0, base16}, 32'h010203);
        wr(8'h26, 8'h0A); wr(8'h27, 8'h0B); wr(8'h28, 8'h0C);
        chk("R3 base8", {8'h0, base8}, 32'h0A0B0C);

        // R11
        wr(8'h09, 8'h12); wr(8'h0A, 8'h34);
        chk("R11 word4", {16'h0, timing_bus[64 +: 16]}, 32'h1234);
        wr(8'h15, 8'hAB); wr(8'h16, 8'hCD);
        chk("R11 word9", {16'h0, timing_bus[144 +: 16]}, 32'hABCD);

        // R4
        wr(8'hFF, 8'h00);
        chk("R4 locked", {31'h0, locked}, 32'h1);
        wr(8'h0F, 8'h07); wr(8'h10, 8'h80); wr(8'h26, 8'hEE);
        chk("R4 hpix held", {16'h0, hpix}, 32'h0500);
        chk("R4 base8 held", {8'h0, base8}, 32'h0A0B0C);

        // R5
        e = '{is_copy: 1'b0, src: 24'h0, len: 8'h0, dst: 24'h0, hp: 16'h0780, b8: 24'hEE0B0C};
        expq.push_back(e);
        send(8'hAF); send(8'h20); send(8'hFF); send(8'hFF); idle();
        chk("R5 hpix", {16'h0, hpix}, 32'h0780);
        chk("R5 base8", {8'h0, base8}, 32'hEE0B0C);
        chk("R5 unlocked", {31'h0, locked}, 32'h0);
        @(negedge clk);
        chk("R5 strobe one cycle", {31'h0, commit}, 32'h0);

        // R10
        wr(8'hFF, 8'h55);
        chk("R10 lock unchanged", {31'h0, locked}, 32'h0);
        wr(8'hFF, 8'h00);
        wr(8'hFF, 8'h12);
        chk("R10 still locked", {31'h0, locked}, 32'h1);
        e.hp = 16'h0780; e.b8 = 24'hEE0B0C;
        expq.push_back(e);
        wr(8'hFF, 8'hFF);

        // R6
        e = '{is_copy: 1'b1, src: 24'h123456, len: 8'h09, dst: 24'hABCDEF, hp: 16'h0, b8: 24'h0};
        expq.push_back(e);
        send(8'hAF); send(8'h6A); send(8'h12); send(8'h34); send(8'h56);
        send(8'h09); send(8'hAB); send(8'hCD); send(8'hEF);
        e = '{is_copy: 1'b1, src: 24'h000000, len: 8'h01, dst: 24'h00FF00, hp: 16'h0, b8: 24'h0};
        expq.push_back(e);
        send(8'hAF); send(8'h6A); send(8'h00); send(8'h00); send(8'h00);
        send(8'h01); send(8'h00); send(8'hFF); send(8'h00); idle();
        @(negedge clk);
        chk("R6 queue drained", expq.size(), 32'd0);

        // R7: padding prefix, then trailing lone prefix
        send(8'hAF); send(8'hAF); send(8'h20); send(8'h00); send(8'h02); idle();
        chk("R7 depth after pad", {24'h0, depth_sel}, 32'h02);
        send(8'hAF); idle();
        chk("R7 no error", {31'h0, err_flag}, 32'h0);
        wr(8'h00, 8'h06);
        chk("R7 next cmd", {24'h0, depth_sel}, 32'h06);

        // R8
        send(8'h11); idle();
        chk("R8 err set", {31'h0, err_flag}, 32'h1);
        wr(8'h00, 8'h03);
        chk("R8 resync", {24'h0, depth_sel}, 32'h03);

        // R9
        send(8'hAF); send(8'h55); send(8'h20); send(8'h00); send(8'h04); idle();
        chk("R9 dropped", {24'h0, depth_sel}, 32'h03);
        wr(8'h00, 8'h05);
        chk("R9 recover", {24'h0, depth_sel}, 32'h05);
        chk("R8 sticky", {31'h0, err_flag}, 32'h1);

        repeat (3) @(negedge clk);
        chk("R5/R6 queue empty", expq.size(), 32'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule